// File: doc/BRIEF.md
# Multichannel Sample-Hold Refresh Sequencer

This block runs the refresh of a bank of sample-and-hold amplifier inputs that all share one DAC. Time is cut into refresh slots. In each slot one channel is selected, the value that channel must hold is presented on the shared code bus, and at the end of the slot that channel's sample strobe pulses for one system clock. Channels are visited in ascending order and the sequence wraps, so every channel is refreshed once per full round of slots.

Slot timing has two sources, picked by a mode input. The first is an internal divider that makes a nominal 100 kHz tick from the system clock. The second is the rising edges of an external oscillator input, which is synchronized into the clock domain. For each slot the block also decides whether the channel uses a fixed preset tap or its programmed register code. A control pin and a force flag make that choice. The preset tap of channel k is step (N − k) of N+1 equal divider steps. The analog divider, the DAC and the amplifiers lie outside this block.

Top module: `shr_refresh_seq`

## Requirements
- R1: During and right after reset, ch_idx is 0, use_reg is 0, code_out is 12 (the channel 0 preset tap), no strobe bit is set, and slot timing is internal.
- R2: In internal mode a slot lasts DIV = CLK_HZ / TICK_HZ system clocks. The first slot after reset release is DIV − 1 clocks long as seen from the release edge.
- R3: Channels are visited 0, 1, …, 11 and then wrap back to 0. ch_idx names the channel of the current slot.
- R4: strobe has one bit per channel, with bit k for channel k. At the end of each slot exactly bit ch_idx is high for a single system clock, while ch_idx still shows that channel. At all other times strobe is 0.
- R5: In external mode slots end only on rising edges of ext_osc. With two synchronizer stages, the strobe is visible in the cycle after the second rising clock edge that follows the ext_osc edge. With no ext_osc edge, no strobe occurs.
- R6: osc_ext_sel (0 = internal, 1 = external) is sampled only at a slot boundary. The slot in progress always completes with the timing it started with, and edges of the other source during it have no effect.
- R7: When the selection is preset, use_reg is 0 and code_out equals 12 − ch_idx, in the low bits with zeros above.
- R8: When ctl_in is high or force_reg is high, use_reg is 1 and code_out equals reg_codes[ch_idx*10 +: 10].
- R9: use_reg and code_out are captured once, at the start of each slot. Changes to ctl_in, force_reg or reg_codes in the middle of a slot leave them unchanged until the next slot begins.
- R10: ctl_in passes through a two-stage synchronizer. A change reaches the next slot only if it is applied at least two rising clock edges before the edge that loads that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| osc_ext_sel | input | 1 | Slot timing source: 0 internal divider, 1 external oscillator |
| ext_osc | input | 1 | External oscillator (asynchronous) |
| ctl_in | input | 1 | Selection pin (asynchronous): high selects register codes |
| force_reg | input | 1 | Force flag: high selects register codes regardless of ctl_in |
| reg_codes | input | 120 | Programmed code per channel, channel k at bits [k*10 +: 10] |
| ch_idx | output | 4 | Channel of the current slot |
| use_reg | output | 1 | 1 when code_out carries the register code, 0 when it carries the preset tap |
| code_out | output | 10 | Value the current channel must hold |
| strobe | output | 12 | One-hot sample strobe, one bit per channel |

## Verification
Each result has its own latency. A strobe is due in the last clock of a slot, and its interval is counted in falling edges from the previous strobe, so an internal slot must come back as exactly DIV. ch_idx, use_reg and code_out for the new slot are due one edge after the strobe, and the bench samples them at the falling edge that follows. An external oscillator edge must produce its strobe at the second falling edge after it, not the first. A ctl_in change placed two edges before the loading edge must reach the new slot, and one placed one edge before it must miss. Changes made in the middle of a slot are checked to stay invisible until the boundary that follows.

// File: rtl/shr_pkg.sv
package shr_pkg;

   typedef enum logic {
      OSC_INT = 1'b0,
      OSC_EXT = 1'b1
   } osc_mode_e;

   // Preset divider step used by a channel: the top channel gets the lowest step.
   function automatic int unsigned preset_tap(input int unsigned num_ch,
                                              input int unsigned ch);
      return num_ch - ch;
   endfunction

endpackage

// File: rtl/shr_tick_gen.sv
module shr_tick_gen
   import shr_pkg::*;
#(
   parameter int unsigned CLK_HZ      = 250_000_000,
   parameter int unsigned TICK_HZ     = 100_000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic osc_ext_sel,
   input  logic ext_osc,
   output logic slot_end
);

   localparam int unsigned DIV   = CLK_HZ / TICK_HZ;
   localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1;

   if (DIV < 2) begin : g_bad_div
      $error("shr_tick_gen: CLK_HZ / TICK_HZ must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("shr_tick_gen: SYNC_STAGES must be at least 2");
   end

   osc_mode_e              mode_q;
   logic [CNT_W-1:0]       cnt_q;
   logic [SYNC_STAGES-1:0] ext_sy_q;
   logic                   ext_last_q;
   logic                   ext_rise;
   logic                   int_wrap;

   // External oscillator: synchronizer chain and rising-edge detector
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_sy_q   <= '0;
         ext_last_q <= 1'b0;
      end else begin
         ext_sy_q   <= {ext_sy_q[SYNC_STAGES-2:0], ext_osc};
         ext_last_q <= ext_sy_q[SYNC_STAGES-1];
      end
   end

   assign ext_rise = ext_sy_q[SYNC_STAGES-1] & ~ext_last_q;
   assign int_wrap = (cnt_q == CNT_W'(DIV - 1));
   assign slot_end = (mode_q == OSC_EXT) ? ext_rise : int_wrap;

   // Internal divider restarts at every boundary so a new slot is always whole
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (slot_end || (mode_q == OSC_EXT)) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   // Timing source is re-sampled only at a slot boundary
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= OSC_INT;
      end else if (slot_end) begin
         mode_q <= osc_ext_sel ? OSC_EXT : OSC_INT;
      end
   end

   AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(DIV - 1)); // R2
   AST_MODE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_end |=> $stable(mode_q)); // R6
   AST_EXT_HOLDS_DIVIDER: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == OSC_EXT) |=> (cnt_q == '0)); // R5

endmodule

// File: rtl/shr_slot_ctr.sv
module shr_slot_ctr #(
   parameter int unsigned NUM_CH = 12,
   parameter int unsigned IDX_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slot_end,
   output logic [IDX_W-1:0]  ch_q,
   output logic [IDX_W-1:0]  nxt_ch,
   output logic [NUM_CH-1:0] strobe
);

   localparam logic [IDX_W-1:0] LAST_CH = IDX_W'(NUM_CH - 1);

   assign nxt_ch = (ch_q == LAST_CH) ? '0 : ch_q + IDX_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ch_q <= '0;
      end else if (slot_end) begin
         ch_q <= nxt_ch;
      end
   end

   // The strobe of the current channel fires in the last clock of its slot
   assign strobe = slot_end ? (NUM_CH'(1) << ch_q) : '0;

   AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(strobe)); // R4
   AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (|strobe) |=> !(|strobe)); // R4
   AST_CH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_end && ch_q != LAST_CH) |=> (ch_q == $past(ch_q) + IDX_W'(1))); // R3
   AST_CH_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_end && ch_q == LAST_CH) |=> (ch_q == '0)); // R3
   AST_CH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ch_q <= LAST_CH); // R3

endmodule

// File: rtl/shr_src_mux.sv
module shr_src_mux
   import shr_pkg::*;
#(
   parameter int unsigned NUM_CH   = 12,
   parameter int unsigned CODE_W   = 10,
   parameter int unsigned IDX_W    = 4,
   parameter bit          CTL_SYNC = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     slot_end,
   input  logic [IDX_W-1:0]         nxt_ch,
   input  logic                     ctl_in,
   input  logic                     force_reg,
   input  logic [NUM_CH*CODE_W-1:0] reg_codes,
   output logic                     use_reg,
   output logic [CODE_W-1:0]        code_out
);

   localparam logic [CODE_W-1:0] RESET_CODE = CODE_W'(preset_tap(NUM_CH, 0));

   logic ctl_s;
   logic sel_next;
   logic [CODE_W-1:0] code_next;

   // Variant: two-stage synchronizer for an asynchronous pin, or direct use
   if (CTL_SYNC) begin : g_ctl_sync
      logic [1:0] ctl_sy_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ctl_sy_q <= '0;
         end else begin
            ctl_sy_q <= {ctl_sy_q[0], ctl_in};
         end
      end
      assign ctl_s = ctl_sy_q[1];
   end else begin : g_ctl_direct
      assign ctl_s = ctl_in;
   end

   assign sel_next  = ctl_s | force_reg;
   assign code_next = sel_next ? reg_codes[nxt_ch*CODE_W +: CODE_W]
                               : CODE_W'(preset_tap(NUM_CH, int'(nxt_ch)));

   // Selection and code are frozen for the whole slot they belong to
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         use_reg  <= 1'b0;
         code_out <= RESET_CODE;
      end else if (slot_end) begin
         use_reg  <= sel_next;
         code_out <= code_next;
      end
   end

   AST_SEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_end |=> ($stable(use_reg) && $stable(code_out))); // R9
   AST_PRESET_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      !use_reg |-> (code_out >= CODE_W'(1) && code_out <= CODE_W'(NUM_CH))); // R7

endmodule

// File: rtl/shr_refresh_seq.sv
module shr_refresh_seq
   import shr_pkg::*;
#(
   parameter int unsigned NUM_CH      = 12,
   parameter int unsigned CODE_W      = 10,
   parameter int unsigned IDX_W       = 4,
   parameter int unsigned CLK_HZ      = 250_000_000,
   parameter int unsigned TICK_HZ     = 100_000,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          CTL_SYNC    = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     osc_ext_sel,
   input  logic                     ext_osc,
   input  logic                     ctl_in,
   input  logic                     force_reg,
   input  logic [NUM_CH*CODE_W-1:0] reg_codes,
   output logic [IDX_W-1:0]         ch_idx,
   output logic                     use_reg,
   output logic [CODE_W-1:0]        code_out,
   output logic [NUM_CH-1:0]        strobe
);

   if (NUM_CH < 2) begin : g_bad_nch
      $error("shr_refresh_seq: NUM_CH must be at least 2");
   end
   if (IDX_W < $clog2(NUM_CH)) begin : g_bad_idx
      $error("shr_refresh_seq: IDX_W too narrow for NUM_CH");
   end
   if (CODE_W < $clog2(NUM_CH + 1)) begin : g_bad_code
      $error("shr_refresh_seq: CODE_W cannot hold the preset taps");
   end

   logic             slot_end;
   logic [IDX_W-1:0] nxt_ch;

   shr_tick_gen #(
      .CLK_HZ      (CLK_HZ),
      .TICK_HZ     (TICK_HZ),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_tick (
      .clk         (clk),
      .rst_n       (rst_n),
      .osc_ext_sel (osc_ext_sel),
      .ext_osc     (ext_osc),
      .slot_end    (slot_end)
   );

   shr_slot_ctr #(
      .NUM_CH (NUM_CH),
      .IDX_W  (IDX_W)
   ) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .slot_end (slot_end),
      .ch_q     (ch_idx),
      .nxt_ch   (nxt_ch),
      .strobe   (strobe)
   );

   shr_src_mux #(
      .NUM_CH   (NUM_CH),
      .CODE_W   (CODE_W),
      .IDX_W    (IDX_W),
      .CTL_SYNC (CTL_SYNC)
   ) u_src (
      .clk       (clk),
      .rst_n     (rst_n),
      .slot_end  (slot_end),
      .nxt_ch    (nxt_ch),
      .ctl_in    (ctl_in),
      .force_reg (force_reg),
      .reg_codes (reg_codes),
      .use_reg   (use_reg),
      .code_out  (code_out)
   );

   AST_STROBE_NAMES_CH: assert property (@(posedge clk) disable iff (!rst_n)
      (|strobe) |-> strobe[ch_idx]); // R4

endmodule

// File: tb/shr_refresh_seq_bench.sv
module shr_refresh_seq_bench;

   localparam int NCH = 12;
   localparam int CW  = 10;
   localparam int DIV = 25;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              osc_ext_sel;
   logic              ext_osc;
   logic              ctl_in;
   logic              force_reg;
   logic [NCH*CW-1:0] reg_codes;
   logic [3:0]        ch_idx;
   logic              use_reg;
   logic [CW-1:0]     code_out;
   logic [NCH-1:0]    strobe;

   int n_chk  = 0;
   int n_fail = 0;
   int exp_ch = 0;
   int used   = 0;

   always #2 clk = ~clk;

   shr_refresh_seq #(
      .CLK_HZ  (250_000_000),
      .TICK_HZ (10_000_000)
   ) u_shr_refresh_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .osc_ext_sel (osc_ext_sel),
      .ext_osc     (ext_osc),
      .ctl_in      (ctl_in),
      .force_reg   (force_reg),
      .reg_codes   (reg_codes),
      .ch_idx      (ch_idx),
      .use_reg     (use_reg),
      .code_out    (code_out),
      .strobe      (strobe)
   );

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   function automatic logic [CW-1:0] reg_val(input int k, input int salt);
      return CW'((k * 97 + salt * 131 + 5) % 1024);
   endfunction

   task automatic load_regs(input int salt);
      for (int k = 0; k < NCH; k++) reg_codes[k*CW +: CW] = reg_val(k, salt);
   endtask

   task automatic tick(input int m);
      repeat (m) @(negedge clk);
      used += m;
   endtask

   // Waits for the next strobe, checks slot length, strobe and channel, then steps one edge
   task automatic see_slot(input int exp_len);
      int n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (strobe == '0 && n < 4000);
      if (exp_len > 0) chk(n + used == exp_len, "R2 slot length", n + used, exp_len);
      chk(strobe == NCH'(1) << ch_idx, "R4 strobe bit", int'(strobe), 1 << ch_idx);
      chk(int'(ch_idx) == exp_ch, "R3 channel order", int'(ch_idx), exp_ch);
      exp_ch = (exp_ch + 1) % NCH;
      @(negedge clk);
      used = 1;
      chk(strobe == '0, "R4 single clock strobe", int'(strobe), 0);
   endtask

   task automatic check_code(input bit want_reg, input int salt, input string req);
      int e;
      e = want_reg ? int'(reg_val(int'(ch_idx), salt)) : NCH - int'(ch_idx);
      chk(use_reg == want_reg, {req, " select flag"}, int'(use_reg), int'(want_reg));
      chk(int'(code_out) == e, {req, " code"}, int'(code_out), e);
   endtask

   task automatic ext_pulse_slot();
      ext_osc = 1'b1;
      @(negedge clk);
      chk(strobe == '0, "R5 no strobe after one edge", int'(strobe), 0);
      @(negedge clk);
      chk(strobe == NCH'(1) << ch_idx, "R5 strobe after two edges", int'(strobe), 1 << ch_idx);
      chk(int'(ch_idx) == exp_ch, "R3 channel order (ext)", int'(ch_idx), exp_ch);
      exp_ch = (exp_ch + 1) % NCH;
      @(negedge clk);
      chk(strobe == '0, "R4 single clock strobe (ext)", int'(strobe), 0);
      ext_osc = 1'b0;
      used = 1;
   endtask

   task automatic quiet_window(input int m, input string req);
      int seen = 0;
      for (int i = 0; i < m; i++) begin
         @(negedge clk);
         if (strobe != '0) seen++;
      end
      chk(seen == 0, req, seen, 0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; osc_ext_sel = 1'b0; ext_osc = 1'b0;
      ctl_in = 1'b0; force_reg = 1'b0; load_regs(0);
      repeat (4) @(negedge clk);
      chk(ch_idx == 4'd0, "R1 reset channel", int'(ch_idx), 0);
      chk(use_reg == 1'b0, "R1 reset select", int'(use_reg), 0);
      chk(code_out == CW'(12), "R1 reset code", int'(code_out), 12);
      chk(strobe == '0, "R1 reset strobe", int'(strobe), 0);
      rst_n = 1'b1;
      used = 0;
      see_slot(DIV - 1);
      check_code(1'b0, 0, "R1 after first slot");
   endtask

   task automatic t_preset_round();
      for (int i = 0; i < NCH + 1; i++) begin
         see_slot(DIV);
         check_code(1'b0, 0, "R7 preset tap");
      end
   endtask

   task automatic t_ctl_select();
      ctl_in = 1'b1;
      for (int i = 0; i < 3; i++) begin
         see_slot(DIV);
         check_code(1'b1, 0, "R8 ctl selects register");
      end
      ctl_in = 1'b0;
      see_slot(DIV);
      check_code(1'b0, 0, "R7 back to preset");
   endtask

   task automatic t_force();
      force_reg = 1'b1;
      see_slot(DIV);
      check_code(1'b1, 0, "R8 force selects register");
      load_regs(1);
      see_slot(DIV);
      check_code(1'b1, 1, "R8 force new codes");
      force_reg = 1'b0;
      see_slot(DIV);
      check_code(1'b0, 1, "R7 force cleared");
   endtask

   task automatic t_midslot();
      int c0;
      tick(5);
      c0 = int'(code_out);
      ctl_in = 1'b1; force_reg = 1'b1; load_regs(2);
      tick(8);
      chk(use_reg == 1'b0, "R9 mid-slot select held", int'(use_reg), 0);
      chk(int'(code_out) == c0, "R9 mid-slot code held", int'(code_out), c0);
      force_reg = 1'b0;
      see_slot(DIV);
      check_code(1'b1, 2, "R9 change applied at boundary");
      ctl_in = 1'b0;
      see_slot(DIV);
      check_code(1'b0, 2, "R9 preset restored");
   endtask

   task automatic t_sync_latency();
      tick(DIV - 2);
      ctl_in = 1'b1;
      see_slot(DIV);
      check_code(1'b0, 2, "R10 late ctl misses slot");
      ctl_in = 1'b0;
      see_slot(DIV);
      check_code(1'b0, 2, "R10 ctl low again");
      tick(DIV - 3);
      ctl_in = 1'b1;
      see_slot(DIV);
      check_code(1'b1, 2, "R10 ctl two edges early hits slot");
      ctl_in = 1'b0;
      see_slot(DIV);
      check_code(1'b0, 2, "R10 ctl released");
   endtask

   task automatic t_external();
      tick(4);
      osc_ext_sel = 1'b1;
      ext_osc = 1'b1;
      tick(4);
      ext_osc = 1'b0;
      see_slot(DIV);
      check_code(1'b0, 2, "R6 internal slot completed");
      quiet_window(60, "R5 no strobe without external edge");
      ext_pulse_slot();
      check_code(1'b0, 2, "R5 code after external slot");
      quiet_window(30, "R5 idle between external edges");
      ext_pulse_slot();
      osc_ext_sel = 1'b0;
      quiet_window(40, "R6 external slot held until edge");
      ext_pulse_slot();
      see_slot(DIV);
      check_code(1'b0, 2, "R6 internal timing resumed");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_preset_round();
      t_ctl_select();
      t_force();
      t_midslot();
      t_sync_latency();
      t_external();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule